// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host pull configuration items out of a small on-chip read-only store, one byte stream at a time. The host first writes a 16-bit selector key. One flag bit of the key picks either the generic bank or the architecture-local bank, and the low bits give the entry index. The host then reads the chosen item through a data register. The block tracks the current item and a byte offset into it. Each read returns the next bytes of the stream and moves the offset forward.

Accesses arrive on one single-cycle request bus that carries a window code. The combined window is a two-byte little-endian I/O window that handles both selection and byte reads. The split form has a big-endian control window for selection and a data window that packs up to `DATA_BYTES` bytes per read. In a wide read the earliest byte sits in the most significant position. If the item ends partway through a read, the remaining byte positions are filled with zeros. A key whose index has no entry leaves the port in an invalid state, and every read then returns zero.

The store contents are computed at elaboration. Key 0 holds a four-byte signature, and generic entry 1 holds an interface version word.

Top module: `cfg_item_port`

## Requirements
- R1: An accepted select write loads the decoded key as the current item and sets the byte offset to zero.
- R2: Key bit 14 selects the architecture-local bank (1) or the generic bank (0), and key bits 13:0 form the entry index; bit 15 is ignored.
- R3: An index at or above `NUM_ENTRIES` makes the current item invalid. Every read then returns zero and leaves the offset unchanged until the next select.
- R4: A read of N bytes returns the item bytes at offsets off..off+N-1, packed so the earliest byte is the most significant of the low N bytes of `acc_rdata`, and advances the offset by N.
- R5: When the item ends inside an N-byte read, the missing low-order byte positions read as zero and the offset stops at the item length.
- R6: A read at the end of an item, or from an item of length 0 (generic entry 2), returns zero and leaves the offset unchanged.
- R7: After reset the current item is key 0, the four-byte signature 4B 43 46 47, read from offset 0.
- R8: Combined window (`acc_win`=0): a 2-byte write at address 0 selects the key {wdata[15:8], wdata[7:0]}. Any 1-byte write is accepted and ignored. A 1-byte read at address 0 or 1 returns one data byte. All other accesses are rejected.
- R9: Control window (`acc_win`=1): only a 2-byte write at address 0 is accepted. It selects the big-endian key {wdata[7:0], wdata[15:8]}.
- R10: Data window (`acc_win`=2): reads of 1 to `DATA_BYTES` bytes at address 0 are accepted. Writes of those sizes are accepted and have no effect on the stream.
- R11: Generic entry 1 is four bytes long. Its first byte is 1 plus 2 when `DMA_PRESENT` is set, and its other bytes are zero.
- R12: Generic entry 0 is the signature and generic entry 2 is empty. Every other entry (bank b, index i) has length ((5*i + 3*b) mod `MAX_LEN`) + 1, and its byte k is (128*b + 16*i + k) mod 256.
- R13: A rejected access (including window 3) gives `acc_ack`=0 and `acc_rdata`=0 in the next cycle, and it changes neither the item nor the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_win | input | 2 | Window: 0 combined, 1 control, 2 data, 3 none |
| acc_addr | input | 1 | Byte address inside the window |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | SZ_W | Access size in bytes |
| acc_wdata | input | 16 | Write data, byte at the lower address in bits 7:0 |
| acc_ack | output | 1 | Access of the previous cycle was accepted |
| acc_rdata | output | 8*DATA_BYTES | Read result of the previous cycle |

## Verification
The assertions check on every cycle the properties that must hold in any state. A select always clears the offset. A read never moves the offset backwards. The offset never passes the current item's length. Reads of an invalid item return zero, and rejected or ignored accesses leave the stream position alone. Only the directed scenarios can show the actual byte values: the signature and version contents, the most-significant-first packing, the zero padding at an item's end, the byte order of the two select windows, and the bank split of the key.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    // Position of the bank flag inside the 16-bit key.
    localparam int ARCH_BIT = 14;

    typedef enum logic [1:0] {
        WIN_COMB = 2'd0,
        WIN_CTRL = 2'd1,
        WIN_DATA = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        OP_REJECT = 2'd0,
        OP_SELECT = 2'd1,
        OP_READ   = 2'd2,
        OP_IGNORE = 2'd3
    } op_e;

    // Length in bytes of entry (bank, idx).
    function automatic int unsigned item_len(int unsigned bank, int unsigned idx,
                                             int unsigned max_len);
        if (bank == 0 && idx <= 1) return 4;
        if (bank == 0 && idx == 2) return 0;
        return ((idx * 5 + bank * 3) % max_len) + 1;
    endfunction

    // Content byte k of entry (bank, idx).
    function automatic logic [7:0] item_byte(int unsigned bank, int unsigned idx,
                                             int unsigned k, bit dma);
        if (bank == 0 && idx == 0) begin
            case (k)
                0:       return 8'h4B;
                1:       return 8'h43;
                2:       return 8'h46;
                default: return 8'h47;
            endcase
        end
        if (bank == 0 && idx == 1) return (k == 0) ? {6'd0, dma, 1'b1} : 8'h00;
        return 8'((bank * 128 + idx * 16 + k) % 256);
    endfunction

endpackage

// File: rtl/cfg_key_decode.sv
module cfg_key_decode
    import cfg_item_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [15:0]      key,
    output logic             key_bank,
    output logic [IDX_W-1:0] key_idx,
    output logic             key_valid
);
    logic [ARCH_BIT-1:0] masked;
    logic                unused_top_bit;

    assign masked         = key[ARCH_BIT-1:0];
    assign key_bank       = key[ARCH_BIT];
    assign key_idx        = masked[IDX_W-1:0];
    assign key_valid      = (32'(masked) < NUM_ENTRIES);
    assign unused_top_bit = key[15];
endmodule

// File: rtl/cfg_access_check.sv
module cfg_access_check
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    localparam int SZ_W = $clog2(DATA_BYTES + 1)
) (
    input  logic            acc_valid,
    input  logic [1:0]      acc_win,
    input  logic            acc_addr,
    input  logic            acc_write,
    input  logic [SZ_W-1:0] acc_size,
    output op_e             op,
    output logic            key_be
);
    win_e win;
    assign win    = win_e'(acc_win);
    assign key_be = (win == WIN_CTRL);

    always_comb begin
        op = OP_REJECT;
        if (acc_valid) begin
            case (win)
                WIN_COMB: begin
                    if (acc_size == SZ_W'(1))
                        op = acc_write ? OP_IGNORE : OP_READ;
                    else if (acc_size == SZ_W'(2) && acc_write && !acc_addr)
                        op = OP_SELECT;
                end
                WIN_CTRL: begin
                    if (acc_size == SZ_W'(2) && acc_write && !acc_addr)
                        op = OP_SELECT;
                end
                WIN_DATA: begin
                    if (!acc_addr && acc_size != '0 && 32'(acc_size) <= DATA_BYTES)
                        op = acc_write ? OP_IGNORE : OP_READ;
                end
                default: op = OP_REJECT;
            endcase
        end
    end
endmodule

// File: rtl/cfg_item_store.sv
module cfg_item_store
    import cfg_item_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int MAX_LEN     = 16,
    parameter int DATA_BYTES  = 8,
    parameter bit DMA_PRESENT = 1'b0,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int OFS_W = $clog2(MAX_LEN + 1),
    localparam int ADR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    localparam int POS_W = $clog2(MAX_LEN + DATA_BYTES + 1)
) (
    input  logic                    rd_bank,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [OFS_W-1:0]        rd_ofs,
    output logic [OFS_W-1:0]        rd_len,
    output logic [8*DATA_BYTES-1:0] rd_bytes
);
    logic [7:0]       rom_byte [2][NUM_ENTRIES][MAX_LEN];
    logic [OFS_W-1:0] len_tab  [2][NUM_ENTRIES];

    // Contents fixed at elaboration from the package fill functions.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
            assign len_tab[b][i] = OFS_W'(item_len(b, i, MAX_LEN));
            for (genvar k = 0; k < MAX_LEN; k++) begin : g_byte
                assign rom_byte[b][i][k] = item_byte(b, i, k, DMA_PRESENT);
            end
        end
    end

    assign rd_len = len_tab[rd_bank][rd_idx];

    // One read port per byte lane; lanes past the item end give zero.
    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
        logic [POS_W-1:0] pos;
        assign pos = POS_W'(rd_ofs) + POS_W'(j);
        assign rd_bytes[j*8 +: 8] = (pos < POS_W'(rd_len)) ?
                                    rom_byte[rd_bank][rd_idx][pos[ADR_W-1:0]] : 8'h00;
    end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int MAX_LEN     = 16,
    parameter int DATA_BYTES  = 8,
    parameter bit DMA_PRESENT = 1'b0,
    localparam int SZ_W  = $clog2(DATA_BYTES + 1),
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int OFS_W = $clog2(MAX_LEN + 1),
    localparam int DW    = 8 * DATA_BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [1:0]      acc_win,
    input  logic            acc_addr,
    input  logic            acc_write,
    input  logic [SZ_W-1:0] acc_size,
    input  logic [15:0]     acc_wdata,
    output logic            acc_ack,
    output logic [DW-1:0]   acc_rdata
);
    typedef struct packed {
        logic             cur_valid;
        logic             cur_bank;
        logic [IDX_W-1:0] cur_idx;
        logic [OFS_W-1:0] ofs;
        logic             ack;
        logic [DW-1:0]    rdata;
    } state_t;

    localparam state_t RST = '{cur_valid: 1'b1, cur_bank: 1'b0, cur_idx: '0,
                               ofs: '0, ack: 1'b0, rdata: '0};

    state_t st_d, st_q;

    op_e              op;
    logic             key_be;
    logic [15:0]      sel_key;
    logic             dec_bank;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_valid;
    logic [OFS_W-1:0] item_len_w;
    logic [DW-1:0]    item_bytes;
    int               rd_n;
    logic [DW-1:0]    wide;
    logic [DW-1:0]    packed_rd;
    int               ofs_sum;

    cfg_access_check #(.DATA_BYTES(DATA_BYTES)) u_check (
        .acc_valid (acc_valid),
        .acc_win   (acc_win),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .op        (op),
        .key_be    (key_be)
    );

    // Control window is big-endian, combined window little-endian.
    assign sel_key = key_be ? {acc_wdata[7:0], acc_wdata[15:8]} : acc_wdata;

    cfg_key_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
        .key       (sel_key),
        .key_bank  (dec_bank),
        .key_idx   (dec_idx),
        .key_valid (dec_valid)
    );

    cfg_item_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .MAX_LEN     (MAX_LEN),
        .DATA_BYTES  (DATA_BYTES),
        .DMA_PRESENT (DMA_PRESENT)
    ) u_store (
        .rd_bank  (st_q.cur_bank),
        .rd_idx   (st_q.cur_idx),
        .rd_ofs   (st_q.ofs),
        .rd_len   (item_len_w),
        .rd_bytes (item_bytes)
    );

    // Byte count of this read: combined window is always one byte.
    assign rd_n = (win_e'(acc_win) == WIN_DATA) ? int'(acc_size) : 1;

    // Pack lanes most-significant-first into the low rd_n bytes.
    always_comb begin
        wide = '0;
        for (int j = 0; j < DATA_BYTES; j++) begin
            if (j < rd_n && st_q.cur_valid)
                wide[(DATA_BYTES-1-j)*8 +: 8] = item_bytes[j*8 +: 8];
        end
        packed_rd = wide >> (8 * (DATA_BYTES - rd_n));
    end

    always_comb begin
        st_d       = st_q;
        st_d.ack   = 1'b0;
        st_d.rdata = '0;
        ofs_sum    = int'(st_q.ofs) + rd_n;
        case (op)
            OP_SELECT: begin
                st_d.ack       = 1'b1;
                st_d.cur_valid = dec_valid;
                st_d.cur_bank  = dec_bank;
                st_d.cur_idx   = dec_idx;
                st_d.ofs       = '0;
            end
            OP_READ: begin
                st_d.ack   = 1'b1;
                st_d.rdata = packed_rd;
                if (st_q.cur_valid && st_q.ofs < item_len_w)
                    st_d.ofs = (ofs_sum >= int'(item_len_w)) ? item_len_w : OFS_W'(ofs_sum);
            end
            OP_IGNORE: st_d.ack = 1'b1;
            default:   st_d.ack = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign acc_ack   = st_q.ack;
    assign acc_rdata = st_q.rdata;

    AST_SEL_CLEARS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SELECT) |=> (st_q.ofs == '0)); // R1

    AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && !st_q.cur_valid) |=> (acc_rdata == '0)); // R3

    AST_READ_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> (st_q.ofs >= $past(st_q.ofs))); // R4

    AST_OFS_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cur_valid |-> (st_q.ofs <= item_len_w)); // R5

    AST_IGNORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IGNORE) |=> ($stable(st_q.ofs) && acc_ack)); // R10

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && op == OP_REJECT) |=>
            (!acc_ack && $stable(st_q.ofs) && $stable(st_q.cur_idx)
             && $stable(st_q.cur_bank) && $stable(st_q.cur_valid))); // R13
endmodule

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
    localparam int NE = 8;
    localparam int ML = 16;
    localparam int DB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_win = 2'd0;
    logic        acc_addr = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_size = 4'd0;
    logic [15:0] acc_wdata = 16'd0;
    logic        acc_ack;
    logic [63:0] acc_rdata;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit m_valid;
    int m_bank, m_idx, m_ofs;

    always #10 clk = ~clk;

    cfg_item_port u_cfg_item_port (
        .clk, .rst_n, .acc_valid, .acc_win, .acc_addr, .acc_write,
        .acc_size, .acc_wdata, .acc_ack, .acc_rdata
    );

    function automatic int exp_len(int b, int i);
        if (b == 0 && i <= 1) return 4;
        if (b == 0 && i == 2) return 0;
        return ((5 * i + 3 * b) % ML) + 1;
    endfunction

    function automatic logic [7:0] exp_byte(int b, int i, int k);
        logic [7:0] sig [4] = '{8'h4B, 8'h43, 8'h46, 8'h47};
        if (b == 0 && i == 0) return sig[k];
        if (b == 0 && i == 1) return (k == 0) ? 8'h01 : 8'h00;
        return 8'((128 * b + 16 * i + k) % 256);
    endfunction

    function automatic void model_select(logic [15:0] key);
        m_bank  = int'(key[14]);
        m_idx   = int'(key[13:0]);
        m_valid = (m_idx < NE);
        m_ofs   = 0;
    endfunction

    function automatic logic [63:0] model_read(int n);
        logic [63:0] v = 64'd0;
        int len;
        len = m_valid ? exp_len(m_bank, m_idx) : 0;
        for (int j = 0; j < n; j++) begin
            logic [7:0] b = (m_valid && m_ofs + j < len) ? exp_byte(m_bank, m_idx, m_ofs + j) : 8'h00;
            v = (v << 8) | 64'(b);
        end
        if (m_valid && m_ofs < len) m_ofs = (m_ofs + n >= len) ? len : m_ofs + n;
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] w, input logic a, input logic wr,
                          input logic [3:0] sz, input logic [15:0] wd,
                          output logic ack, output logic [63:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_win = w; acc_addr = a; acc_write = wr;
        acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        ack = acc_ack; rd = acc_rdata;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] w, input logic a, input int n, input string req);
        logic ack; logic [63:0] rd, exp;
        access(w, a, 1'b0, 4'(n), 16'd0, ack, rd);
        exp = model_read(n);
        chk(ack == 1'b1, {req, " ack"}, 64'(ack), 64'd1);
        chk(rd == exp, req, rd, exp);
    endtask

    task automatic do_select(input logic [1:0] w, input logic [15:0] key, input string req);
        logic ack; logic [63:0] rd;
        logic [15:0] wd = (w == 2'd1) ? {key[7:0], key[15:8]} : key;
        access(w, 1'b0, 1'b1, 4'd2, wd, ack, rd);
        model_select(key);
        chk(ack == 1'b1, {req, " select ack"}, 64'(ack), 64'd1);
    endtask

    task automatic t_reset();
        chk(acc_ack == 1'b0 && acc_rdata == 64'd0, "R7 reset outputs", {acc_rdata[62:0], acc_ack}, 64'd0);
        model_select(16'h0000);
        do_read(2'd2, 1'b0, 4, "R7 signature");
        do_read(2'd2, 1'b0, 1, "R6 read past end");
    endtask

    task automatic t_id_item();
        do_select(2'd0, 16'h0001, "R8 combined select");
        do_read(2'd2, 1'b0, 4, "R11 version word");
    endtask

    task automatic t_pad();
        do_select(2'd0, 16'h0004, "R5 select");
        do_read(2'd2, 1'b0, 8, "R5 padded read R12");
        do_read(2'd2, 1'b0, 2, "R6 after end");
    endtask

    task automatic t_stream();
        do_select(2'd0, 16'h0003, "R4 select");
        do_read(2'd0, 1'b0, 1, "R8 combined byte addr0");
        do_read(2'd0, 1'b1, 1, "R8 combined byte addr1");
        do_read(2'd2, 1'b0, 3, "R4 three byte read");
        do_read(2'd2, 1'b0, 8, "R4 eight byte read R12");
        do_read(2'd2, 1'b0, 8, "R5 tail padding");
    endtask

    task automatic t_invalid();
        do_select(2'd0, 16'h0008, "R3 select");
        do_read(2'd2, 1'b0, 8, "R3 invalid index");
        do_select(2'd0, 16'h3FFF, "R3 select max");
        do_read(2'd0, 1'b0, 1, "R3 invalid byte");
    endtask

    task automatic t_banks();
        do_select(2'd1, 16'h4002, "R9 control select");
        do_read(2'd2, 1'b0, 8, "R9 big-endian key bank1 R2");
        do_select(2'd0, 16'h4000, "R2 bank1 idx0");
        do_read(2'd2, 1'b0, 8, "R2 bank1 entry0 R12");
        do_select(2'd0, 16'hC000, "R2 bit15 ignored");
        do_read(2'd2, 1'b0, 2, "R2 bit15 ignored read");
    endtask

    task automatic t_empty();
        do_select(2'd0, 16'h0002, "R6 select empty");
        do_read(2'd2, 1'b0, 4, "R6 empty item");
    endtask

    task automatic t_ignore();
        logic ack; logic [63:0] rd;
        do_select(2'd0, 16'h0005, "R10 select");
        do_read(2'd2, 1'b0, 2, "R10 first read");
        access(2'd2, 1'b0, 1'b1, 4'd4, 16'hFFFF, ack, rd);
        chk(ack == 1'b1, "R10 data write ack", 64'(ack), 64'd1);
        access(2'd0, 1'b1, 1'b1, 4'd1, 16'h00AA, ack, rd);
        chk(ack == 1'b1, "R8 byte write ack", 64'(ack), 64'd1);
        do_read(2'd2, 1'b0, 2, "R10 stream unchanged");
    endtask

    task automatic t_reject();
        logic ack; logic [63:0] rd;
        do_select(2'd0, 16'h0006, "R13 select");
        do_read(2'd2, 1'b0, 1, "R13 first read");
        access(2'd1, 1'b0, 1'b0, 4'd2, 16'd0, ack, rd);
        chk(!ack && rd == 0, "R9 control read rejected", {rd[62:0], ack}, 64'd0);
        access(2'd1, 1'b0, 1'b1, 4'd1, 16'h0001, ack, rd);
        chk(!ack, "R9 control byte write rejected", 64'(ack), 64'd0);
        access(2'd0, 1'b0, 1'b0, 4'd2, 16'd0, ack, rd);
        chk(!ack && rd == 0, "R8 combined word read rejected", {rd[62:0], ack}, 64'd0);
        access(2'd2, 1'b0, 1'b0, 4'd9, 16'd0, ack, rd);
        chk(!ack && rd == 0, "R13 oversize read rejected", {rd[62:0], ack}, 64'd0);
        access(2'd2, 1'b0, 1'b0, 4'd0, 16'd0, ack, rd);
        chk(!ack, "R13 zero size rejected", 64'(ack), 64'd0);
        access(2'd3, 1'b0, 1'b1, 4'd2, 16'h0001, ack, rd);
        chk(!ack, "R13 window 3 rejected", 64'(ack), 64'd0);
        do_read(2'd2, 1'b0, 4, "R13 state unchanged");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_item();
        t_pad();
        t_stream();
        t_invalid();
        t_banks();
        t_empty();
        t_ignore();
        t_reject();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule